// File: doc/BRIEF.md
# Cross-Lane Ring Transfer Unit

This unit carries single data words from one virtual processor to its successor, where the virtual processors are striped round-robin over four lanes. Virtual processor v lives on lane v mod 4. A value that virtual processor n sends can only reach virtual processor n+1, which sits on the next lane. The link from lane 3 wraps back to lane 0 and so reaches the next group of virtual processor numbers. Each link is a small first-in first-out buffer with a valid/ready handshake. A transfer therefore completes only once the producer has sent its value, and a receiver with nothing to take simply waits.

A start/stop queue sits at the edge of the ring. The control side pushes a seed value into it, and virtual processor 0 takes that seed instead of reading a ring link. The active vector length marks one virtual processor as the last. That processor's value goes into the start/stop queue rather than onward to the next lane. The control side can then pop the value. It can also leave it in the queue, and virtual processor 0 consumes it as the seed of the next run.

Top module: `xvp_ring`

## Requirements
- R1: After reset, `ssq_empty` is 1, `ssq_full` is 0 and every bit of `rcv_valid` is 0.
- R2: An accepted send on lane i goes into the link toward lane (i+1) mod 4, with lane 3 wrapping to lane 0, when its `snd_vp` is not `vlen`-1. The link holds 2 words, and `snd_ready[i]` for such a send is 1 exactly when the link holds fewer than 2.
- R3: Lane i with i in 1..3, and lane 0 when `rcv0_vp` is not 0, receives from the link out of lane (i+3) mod 4. `rcv_valid[i]` is 1 exactly when that link holds a word, `rcv_data` shows the oldest word, and `rcv_req[i]` with `rcv_valid[i]` removes it. Words arrive in the order they were sent.
- R4: When `rcv_req` meets an empty source, `rcv_valid` stays 0 and nothing is removed. A word that is waiting stays unchanged on `rcv_data` until it is taken.
- R5: When `rcv0_vp` is 0, lane 0 receives the head of the start/stop queue instead of a link, and `rcv_valid[0]` is 1 exactly when the queue is not empty.
- R6: A send whose `snd_vp` equals `vlen`-1 goes to the start/stop queue and never to a link. It is accepted only when the queue is not full, `ctl_push` is 0, and no lower-numbered lane makes such a send in the same cycle.
- R7: `ctl_push` appends `ctl_push_data` to the start/stop queue when the queue is not full. When the queue is full, `ctl_push_refused` is 1 in the same cycle and the queue does not change.
- R8: The start/stop queue holds 4 words. `ssq_full` shows 4 entries and `ssq_empty` shows 0 entries.
- R9: `ctl_pop_data` shows the head of the start/stop queue. `ctl_pop` removes that head unless lane 0 takes from the queue in the same cycle, in which case the lane takes it and the pop has no effect. A pop from an empty queue is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vlen | input | 8 | Active vector length; the virtual processor numbered vlen-1 is the last |
| snd_valid | input | 4 | Per-lane send request |
| snd_vp | input | 28 | Per-lane sending virtual processor number, 7 bits per lane |
| snd_data | input | 128 | Per-lane send word, 32 bits per lane |
| snd_ready | output | 4 | Per-lane send accepted |
| rcv_req | input | 4 | Per-lane receive request |
| rcv0_vp | input | 7 | Virtual processor number receiving on lane 0 |
| rcv_valid | output | 4 | Per-lane receive word available |
| rcv_data | output | 128 | Per-lane received word, 32 bits per lane |
| ctl_push | input | 1 | Control push into the start/stop queue |
| ctl_push_data | input | 32 | Word to push |
| ctl_push_refused | output | 1 | Push refused because the queue is full |
| ctl_pop | input | 1 | Control pop from the start/stop queue |
| ctl_pop_data | output | 32 | Head of the start/stop queue |
| ssq_full | output | 1 | Start/stop queue holds 4 words |
| ssq_empty | output | 1 | Start/stop queue holds no word |

## Verification
A wrong link occupancy shows in the same cycle as a wrong `snd_ready` on the producer's lane or a wrong `rcv_valid` on the consumer's lane. A word that is lost, duplicated or reordered shows on `rcv_data` the first time the consumer is offered that slot. A wrong start/stop queue count shows at once on `ssq_full`, `ssq_empty` or `ctl_push_refused`. A wrong head shows on `ctl_pop_data`, and also on lane 0 whenever `rcv0_vp` is 0. The bench keeps a behavioural queue model and compares every output on every clock, so the first cycle of any divergence is reported.

// File: rtl/xvp_ring_pkg.sv
package xvp_ring_pkg;

    localparam int NLANE_DEF     = 4;
    localparam int WORD_W_DEF    = 32;
    localparam int VP_W_DEF      = 7;
    localparam int HOP_DEPTH_DEF = 2;
    localparam int SSQ_DEPTH_DEF = 4;

    // Where a lane's send is steered this cycle
    typedef enum logic [1:0] {
        ROUTE_IDLE = 2'd0,
        ROUTE_HOP  = 2'd1,
        ROUTE_SSQ  = 2'd2
    } route_e;

    // Lane that feeds lane 'lane' around the ring
    function automatic int prev_lane(input int lane, input int nlane);
        return (lane + nlane - 1) % nlane;
    endfunction

    // Lane fed by lane 'lane' around the ring
    function automatic int next_lane(input int lane, input int nlane);
        return (lane + 1) % nlane;
    endfunction

endpackage

// File: rtl/xvp_fifo.sv
module xvp_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

endmodule

// File: rtl/xvp_send_route.sv
module xvp_send_route
    import xvp_ring_pkg::*;
#(
    parameter int VP_W = VP_W_DEF
) (
    input  logic            snd_valid,
    input  logic [VP_W-1:0] snd_vp,
    input  logic [VP_W:0]   vlen,
    output route_e          route
);
    logic is_last;

    // vlen of zero wraps to all ones and so never matches
    assign is_last = ({1'b0, snd_vp} == (vlen - 1'b1));

    always_comb begin
        if (!snd_valid)   route = ROUTE_IDLE;
        else if (is_last) route = ROUTE_SSQ;
        else              route = ROUTE_HOP;
    end

endmodule

// File: rtl/xvp_ring.sv
module xvp_ring
    import xvp_ring_pkg::*;
#(
    parameter int NLANE     = NLANE_DEF,
    parameter int WORD_W    = WORD_W_DEF,
    parameter int VP_W      = VP_W_DEF,
    parameter int HOP_DEPTH = HOP_DEPTH_DEF,
    parameter int SSQ_DEPTH = SSQ_DEPTH_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [VP_W:0]           vlen,
    input  logic [NLANE-1:0]        snd_valid,
    input  logic [NLANE*VP_W-1:0]   snd_vp,
    input  logic [NLANE*WORD_W-1:0] snd_data,
    output logic [NLANE-1:0]        snd_ready,
    input  logic [NLANE-1:0]        rcv_req,
    input  logic [VP_W-1:0]         rcv0_vp,
    output logic [NLANE-1:0]        rcv_valid,
    output logic [NLANE*WORD_W-1:0] rcv_data,
    input  logic                    ctl_push,
    input  logic [WORD_W-1:0]       ctl_push_data,
    output logic                    ctl_push_refused,
    input  logic                    ctl_pop,
    output logic [WORD_W-1:0]       ctl_pop_data,
    output logic                    ssq_full,
    output logic                    ssq_empty
);
    route_e              route     [NLANE];
    logic [WORD_W-1:0]   hop_rdata [NLANE];
    logic [NLANE-1:0]    hop_push, hop_pop, hop_full, hop_empty;
    logic [NLANE-1:0]    ssq_gnt, take;
    logic                ssq_push, ssq_pop, lane0_from_ssq, lane0_ssq_take;
    logic [WORD_W-1:0]   ssq_wdata;

    assign lane0_from_ssq = (rcv0_vp == '0);

    // Per-lane send steering and ring link
    for (genvar i = 0; i < NLANE; i++) begin : g_lane
        xvp_send_route #(.VP_W(VP_W)) u_route (
            .snd_valid (snd_valid[i]),
            .snd_vp    (snd_vp[i*VP_W +: VP_W]),
            .vlen      (vlen),
            .route     (route[i])
        );

        xvp_fifo #(.W(WORD_W), .DEPTH(HOP_DEPTH)) u_hop (
            .clk   (clk),
            .rst   (rst),
            .push  (hop_push[i]),
            .pop   (hop_pop[i]),
            .wdata (snd_data[i*WORD_W +: WORD_W]),
            .rdata (hop_rdata[i]),
            .full  (hop_full[i]),
            .empty (hop_empty[i])
        );

        assign hop_push[i]  = (route[i] == ROUTE_HOP) && !hop_full[i];
        assign snd_ready[i] = (route[i] == ROUTE_SSQ) ? ssq_gnt[i] : !hop_full[i];
    end

    // Receive side: each lane reads the link of its ring predecessor
    for (genvar i = 0; i < NLANE; i++) begin : g_rcv
        localparam int PL = prev_lane(i, NLANE);
        if (i == 0) begin : g_edge
            assign rcv_valid[i] = lane0_from_ssq ? !ssq_empty : !hop_empty[PL];
            assign rcv_data[i*WORD_W +: WORD_W] = lane0_from_ssq ? ctl_pop_data : hop_rdata[PL];
        end else begin : g_mid
            assign rcv_valid[i] = !hop_empty[PL];
            assign rcv_data[i*WORD_W +: WORD_W] = hop_rdata[PL];
        end
        assign take[i] = rcv_req[i] && rcv_valid[i];
    end

    for (genvar j = 0; j < NLANE; j++) begin : g_pop
        localparam int NL = next_lane(j, NLANE);
        if (NL == 0) begin : g_wrap
            assign hop_pop[j] = take[0] && !lane0_from_ssq;
        end else begin : g_fwd
            assign hop_pop[j] = take[NL];
        end
    end

    // Start/stop queue write arbitration: control first, then lowest lane
    always_comb begin
        logic blocked;
        blocked   = ctl_push || ssq_full;
        ssq_gnt   = '0;
        ssq_wdata = ctl_push_data;
        for (int i = 0; i < NLANE; i++) begin
            if (route[i] == ROUTE_SSQ && !blocked) begin
                ssq_gnt[i] = 1'b1;
                ssq_wdata  = snd_data[i*WORD_W +: WORD_W];
                blocked    = 1'b1;
            end
        end
    end

    assign ssq_push         = (ctl_push && !ssq_full) || (|ssq_gnt);
    assign ctl_push_refused = ctl_push && ssq_full;
    assign lane0_ssq_take   = take[0] && lane0_from_ssq;
    assign ssq_pop          = lane0_ssq_take || (ctl_pop && !ssq_empty);

    xvp_fifo #(.W(WORD_W), .DEPTH(SSQ_DEPTH)) u_ssq (
        .clk   (clk),
        .rst   (rst),
        .push  (ssq_push),
        .pop   (ssq_pop),
        .wdata (ssq_wdata),
        .rdata (ctl_pop_data),
        .full  (ssq_full),
        .empty (ssq_empty)
    );

endmodule

// File: rtl/xvp_ring_chk.sv
module xvp_ring_chk #(
    parameter int NLANE  = 4,
    parameter int WORD_W = 32,
    parameter int VP_W   = 7
) (
    input logic                    clk,
    input logic                    rst,
    input logic [VP_W:0]           vlen,
    input logic [NLANE-1:0]        snd_valid,
    input logic [NLANE*VP_W-1:0]   snd_vp,
    input logic [NLANE-1:0]        snd_ready,
    input logic [NLANE-1:0]        rcv_req,
    input logic [VP_W-1:0]         rcv0_vp,
    input logic [NLANE-1:0]        rcv_valid,
    input logic [NLANE*WORD_W-1:0] rcv_data,
    input logic                    ctl_push,
    input logic                    ctl_pop,
    input logic                    ssq_full,
    input logic                    ssq_empty,
    input logic [NLANE-1:0]        hop_empty,
    input logic                    ssq_pop
);
    logic [NLANE-1:0] last_snd;

    for (genvar i = 0; i < NLANE; i++) begin : g_a
        assign last_snd[i] = snd_valid[i] && ({1'b0, snd_vp[i*VP_W +: VP_W]} == (vlen - 1'b1));

        assert_hop_holds_R2: assert property (@(posedge clk) disable iff (rst)
            (snd_valid[i] && snd_ready[i] && !last_snd[i]) |=> !hop_empty[i]);

        assert_last_blocked_R6: assert property (@(posedge clk) disable iff (rst)
            (last_snd[i] && ssq_full) |-> !snd_ready[i]);

        if (i != 0) begin : g_mid
            assert_wait_stable_R4: assert property (@(posedge clk) disable iff (rst)
                (rcv_valid[i] && !rcv_req[i]) |=>
                (rcv_valid[i] && $stable(rcv_data[i*WORD_W +: WORD_W])));
        end else begin : g_edge
            assert_edge_stable_R4: assert property (@(posedge clk) disable iff (rst)
                (rcv_valid[0] && !rcv_req[0] && !ctl_pop) |=>
                ($stable(rcv0_vp) -> (rcv_valid[0] && $stable(rcv_data[WORD_W-1:0]))));
        end
    end

    assert_seed_lands_R7: assert property (@(posedge clk) disable iff (rst)
        (ctl_push && !ssq_full) |=> !ssq_empty);

    assert_full_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (ssq_full && !ssq_pop) |=> ssq_full);

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ssq_full, ssq_empty}));

endmodule

bind xvp_ring xvp_ring_chk #(
    .NLANE  (NLANE),
    .WORD_W (WORD_W),
    .VP_W   (VP_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .vlen      (vlen),
    .snd_valid (snd_valid),
    .snd_vp    (snd_vp),
    .snd_ready (snd_ready),
    .rcv_req   (rcv_req),
    .rcv0_vp   (rcv0_vp),
    .rcv_valid (rcv_valid),
    .rcv_data  (rcv_data),
    .ctl_push  (ctl_push),
    .ctl_pop   (ctl_pop),
    .ssq_full  (ssq_full),
    .ssq_empty (ssq_empty),
    .hop_empty (hop_empty),
    .ssq_pop   (ssq_pop)
);

// File: tb/xvp_ring_tb.sv
module xvp_ring_tb;
    localparam int NL = 4;
    localparam int DW = 32;
    localparam int VW = 7;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [VW:0]     vlen = 8'd6;
    logic [NL-1:0]   snd_valid = '0;
    logic [NL*VW-1:0] snd_vp;
    logic [NL*DW-1:0] snd_data;
    logic [NL-1:0]   snd_ready;
    logic [NL-1:0]   rcv_req = '0;
    logic [VW-1:0]   rcv0_vp = 7'd1;
    logic [NL-1:0]   rcv_valid;
    logic [NL*DW-1:0] rcv_data;
    logic            ctl_push = 1'b0;
    logic [DW-1:0]   ctl_push_data = '0;
    logic            ctl_push_refused;
    logic            ctl_pop = 1'b0;
    logic [DW-1:0]   ctl_pop_data;
    logic            ssq_full, ssq_empty;

    logic [VW-1:0]   b_vp [NL];
    logic [DW-1:0]   b_sd [NL];

    always_comb begin
        for (int i = 0; i < NL; i++) begin
            snd_vp[i*VW +: VW] = b_vp[i];
            snd_data[i*DW +: DW] = b_sd[i];
        end
    end

    always #10 clk = ~clk;

    xvp_ring u_dut (
        .clk(clk), .rst(rst), .vlen(vlen),
        .snd_valid(snd_valid), .snd_vp(snd_vp), .snd_data(snd_data), .snd_ready(snd_ready),
        .rcv_req(rcv_req), .rcv0_vp(rcv0_vp), .rcv_valid(rcv_valid), .rcv_data(rcv_data),
        .ctl_push(ctl_push), .ctl_push_data(ctl_push_data), .ctl_push_refused(ctl_push_refused),
        .ctl_pop(ctl_pop), .ctl_pop_data(ctl_pop_data),
        .ssq_full(ssq_full), .ssq_empty(ssq_empty)
    );

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic [DW-1:0] hopq [NL][$];
    logic [DW-1:0] ssq [$];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FIFO mismatch FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    // Compare all outputs against the queue model, then advance the model one clock
    task automatic cycle();
        bit last [NL];
        bit gnt  [NL];
        bit blocked;
        bit e_ready, e_valid, from_ssq;
        logic [DW-1:0] e_data;
        bit take [NL];
        #5;
        blocked = ctl_push || (ssq.size() == 4);
        for (int i = 0; i < NL; i++) begin
            last[i] = snd_valid[i] && (int'(b_vp[i]) == int'(vlen) - 1);
            gnt[i]  = 1'b0;
            if (last[i] && !blocked) begin
                gnt[i] = 1'b1;
                blocked = 1'b1;
            end
        end
        from_ssq = (rcv0_vp == 0);
        for (int i = 0; i < NL; i++) begin
            e_ready = last[i] ? gnt[i] : (hopq[i].size() < 2);
            check(snd_ready[i] == e_ready, last[i] ? "R6" : "R2", $sformatf("snd_ready[%0d]", i),
                  snd_ready[i], e_ready);
            if (i == 0 && from_ssq) begin
                e_valid = (ssq.size() > 0);
                e_data  = e_valid ? ssq[0] : '0;
                check(rcv_valid[0] == e_valid, "R5", "rcv_valid[0]", rcv_valid[0], e_valid);
                if (e_valid)
                    check(rcv_data[DW-1:0] == e_data, "R5", "rcv_data[0]", rcv_data[DW-1:0], e_data);
            end else begin
                int p;
                p = (i + NL - 1) % NL;
                e_valid = (hopq[p].size() > 0);
                e_data  = e_valid ? hopq[p][0] : '0;
                check(rcv_valid[i] == e_valid, e_valid ? "R3" : "R4", $sformatf("rcv_valid[%0d]", i),
                      rcv_valid[i], e_valid);
                if (e_valid)
                    check(rcv_data[i*DW +: DW] == e_data, "R3", $sformatf("rcv_data[%0d]", i),
                          rcv_data[i*DW +: DW], e_data);
            end
            take[i] = rcv_req[i] && e_valid;
        end
        check(ssq_full == (ssq.size() == 4), "R8", "ssq_full", ssq_full, ssq.size() == 4);
        check(ssq_empty == (ssq.size() == 0), "R8", "ssq_empty", ssq_empty, ssq.size() == 0);
        check(ctl_push_refused == (ctl_push && ssq.size() == 4), "R7", "ctl_push_refused",
              ctl_push_refused, ctl_push && ssq.size() == 4);
        if (ssq.size() > 0)
            check(ctl_pop_data == ssq[0], "R9", "ctl_pop_data", ctl_pop_data, ssq[0]);

        // model update: removals first, then appends
        if (take[0] && from_ssq) void'(ssq.pop_front());
        else if (ctl_pop && ssq.size() > 0) void'(ssq.pop_front());
        for (int i = 0; i < NL; i++) begin
            if (take[i] && !(i == 0 && from_ssq)) void'(hopq[(i + NL - 1) % NL].pop_front());
        end
        if (ctl_push) begin
            if (!(ssq.size() == 4 && !(take[0] && from_ssq) && !ctl_pop) && !blocked_full(ctl_push))
                ssq.push_back(ctl_push_data);
        end
        for (int i = 0; i < NL; i++) begin
            if (gnt[i]) ssq.push_back(b_sd[i]);
            if (snd_valid[i] && !last[i] && pre_size[i] < 2) hopq[i].push_back(b_sd[i]);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    // Occupancy snapshot taken at the start of each cycle, before removals
    int  pre_size [NL];
    bit  pre_ssq_full;

    function automatic bit blocked_full(input bit p);
        return p && pre_ssq_full;
    endfunction

    task automatic step();
        for (int i = 0; i < NL; i++) pre_size[i] = hopq[i].size();
        pre_ssq_full = (ssq.size() == 4);
        cycle();
    endtask

    task automatic idle();
        snd_valid = '0;
        rcv_req   = '0;
        rcv0_vp   = 7'd1;
        ctl_push  = 1'b0;
        ctl_pop   = 1'b0;
        for (int i = 0; i < NL; i++) begin
            b_vp[i] = '0;
            b_sd[i] = '0;
        end
    endtask

    task automatic send(input int lane, input int vp, input logic [DW-1:0] d);
        snd_valid[lane] = 1'b1;
        b_vp[lane] = VW'(vp);
        b_sd[lane] = d;
    endtask

    initial begin
        #(200000 * 20);
        vectors++;
        errors++;
        $display("Watchdog FAIL: run did not end");
        finish_run();
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #5;
        // R1: state right after reset
        check(ssq_empty == 1'b1, "R1", "ssq_empty", ssq_empty, 1);
        check(ssq_full == 1'b0, "R1", "ssq_full", ssq_full, 0);
        check(rcv_valid == '0, "R1", "rcv_valid", rcv_valid, 0);
        @(negedge clk);

        // R7 R8: fill the start/stop queue, fifth push refused
        vlen = 8'd6;
        for (int k = 0; k < 5; k++) begin
            idle(); ctl_push = 1'b1; ctl_push_data = 32'h11 + k; step();
        end
        // R9: drain, last pop on empty ignored
        for (int k = 0; k < 5; k++) begin
            idle(); ctl_pop = 1'b1; step();
        end
        // R5 R9: seed then lane 0 takes it while control pops
        idle(); ctl_push = 1'b1; ctl_push_data = 32'hA0; step();
        idle(); ctl_push = 1'b1; ctl_push_data = 32'hA1; step();
        idle(); rcv_req[0] = 1'b1; rcv0_vp = 7'd0; ctl_pop = 1'b1; step();
        idle(); ctl_pop = 1'b1; step();
        // R6: last virtual processor goes to the queue, reused as next seed
        idle(); send(1, 5, 32'h55); step();
        idle(); rcv_req[0] = 1'b1; rcv0_vp = 7'd0; step();
        // R2 R3: wrap from lane 3 to lane 0
        idle(); send(3, 3, 32'h33); step();
        idle(); rcv_req[0] = 1'b1; rcv0_vp = 7'd4; step();
        // R2: link fills after two words
        for (int k = 0; k < 3; k++) begin
            idle(); send(2, 2, 32'h21 + k); step();
        end
        for (int k = 0; k < 3; k++) begin
            idle(); rcv_req[3] = 1'b1; step();
        end
        // R4: receive with nothing there
        idle(); rcv_req[1] = 1'b1; step();
        // R6: two lanes both last, lowest wins; control push blocks both
        idle(); vlen = 8'd2; send(1, 1, 32'hB1); send(2, 1, 32'hB2); step();
        idle(); vlen = 8'd2; send(1, 1, 32'hC1); ctl_push = 1'b1; ctl_push_data = 32'hC0; step();

        // Mixed traffic
        for (int n = 0; n < 3000; n++) begin
            idle();
            if (n % 50 == 0) vlen = 8'($urandom_range(1, 8));
            for (int i = 0; i < NL; i++) begin
                if ($urandom_range(0, 1) == 1) send(i, $urandom_range(0, 7), $urandom());
                rcv_req[i] = ($urandom_range(0, 2) != 0);
            end
            rcv0_vp       = ($urandom_range(0, 2) == 0) ? 7'd0 : 7'($urandom_range(1, 7));
            ctl_push      = ($urandom_range(0, 3) == 0);
            ctl_push_data = $urandom();
            ctl_pop       = ($urandom_range(0, 4) == 0);
            step();
        end
        finish_run();
    end

endmodule